// File: doc/BRIEF.md
# Edge-Capture Interval Timer

This block is a single 16-bit timer channel that measures the time between edges on an asynchronous input pin. A count clock is derived from the system clock by a power-of-two prescaler. On every valid edge of the pin, the running count is copied into a capture register and the counter restarts at once. The captured value is therefore the interval itself, and software does not need to subtract successive readings. A one-cycle interrupt pulse marks each new capture. A status bit returned with the capture reports whether the counter wrapped during that interval.

Four edge modes are offered:
- Falling edge: every falling edge captures and restarts.
- Rising edge: every rising edge captures and restarts.
- Low width: the counter restarts on the falling edge and captures on the next rising edge.
- High width: the counter restarts on the rising edge and captures on the next falling edge.

Start and stop are single-cycle trigger pulses, and configuration is taken from plain input pins. The capture output is a holding register qualified by the interrupt pulse, not a stream. It has no back-pressure: a later capture overwrites an unread one.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, the capture value is 0, the wrap status is 0, the interrupt is low and the channel is stopped.
- R2: With prescale select n (0 to 15), the counter advances once every 2^n system clocks while running. Two valid edges that arrive D clocks apart, with D a multiple of 2^n, capture the value D/2^n.
- R3: A start pulse clears the counter and the wrap tracker and enables counting, without raising the interrupt. With n = 0, a rising-edge-mode edge whose pin change is first sampled at the (N+1)th clock after the start clock captures N+2.
- R4: With the default two-flop synchronizer, a pin change first sampled at clock edge k updates the capture value and the status at clock edge k+2. The interrupt is high during the cycle that follows edge k+2. The capture value and the status change at no other time.
- R5: The interrupt is high for exactly one cycle per capture.
- R6: Edge select 2'b00 captures on falling edges and 2'b01 captures on rising edges; pin edges of the other polarity produce no capture.
- R7: Edge select 2'b10 restarts the counter on a falling edge and captures the low width on the next rising edge. Edge select 2'b11 restarts on a rising edge and captures the high width on the next falling edge.
- R8: The wrap status (bit 0 of the status) is 1 when the counter passed FFFFh since the previous capture or restart, and 0 otherwise. With n = 0, an interval of 65636 clocks captures 100 with the status set, and a following interval of 50 clocks captures 50 with the status clear.
- R9: After a stop pulse the counter halts and pin edges cause no interrupt. The capture value and the status stay unchanged until the channel is started again.
- R10: When start and stop are pulsed in the same cycle, stop takes effect and the channel stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start trigger pulse: clear counter and run |
| stop_i | input | 1 | Stop trigger pulse: halt counting and ignore edges |
| presc_sel_i | input | 4 | Count clock = system clock / 2^presc_sel_i |
| edge_sel_i | input | 2 | Edge mode: 00 fall, 01 rise, 10 low width, 11 high width |
| pin_i | input | 1 | Asynchronous measured input |
| cap_o | output | 16 | Last captured interval |
| ovf_o | output | 1 | Wrap status of the last captured interval |
| irq_o | output | 1 | One-cycle pulse after each capture |

## Verification
The hardest case to reach is the wrap status. It needs an interval longer than the full 16-bit range, followed at once by a short one, to show that the status is set and then cleared again on the next capture. The stimulus runs the fastest count clock in rising-edge mode. It holds the pin low for about 65 600 clocks between two rises and then sends a 50-clock interval. The expected values follow from R8: the wrapped residue 100 with the status set, then 50 with the status clear. The restart-then-capture behaviour of the two width modes is reached with asymmetric pulse trains, so that a high-width and a low-width reading cannot be mistaken for each other.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL      = 2'b00,
    EDGE_RISE      = 2'b01,
    EDGE_LOW_WIDTH = 2'b10,
    EDGE_HI_WIDTH  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/ect_prescaler.sv
module ect_prescaler #(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  localparam int DIV_W = (1 << PSEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // low sel bits of the divider all ones -> one tick per 2^sel clocks
  assign mask   = ~({DIV_W{1'b1}} << sel_i);
  assign tick_o = en_i && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (en_i)  div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/ect_edge_detect.sv
module ect_edge_detect
  import ect_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  output logic       cap_ev_o,
  output logic       rst_ev_o
);
  // stages 0..SYNC_STAGES-1 synchronize, the last stage holds the previous level
  logic [SYNC_STAGES:0] shr_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr_q <= '0;
    else        shr_q <= {shr_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise = shr_q[SYNC_STAGES-1] & ~shr_q[SYNC_STAGES];
  assign fall = ~shr_q[SYNC_STAGES-1] & shr_q[SYNC_STAGES];

  always_comb begin
    cap_ev_o = 1'b0;
    rst_ev_o = 1'b0;
    case (edge_mode_e'(mode_i))
      EDGE_FALL:      cap_ev_o = fall;
      EDGE_RISE:      cap_ev_o = rise;
      EDGE_LOW_WIDTH: begin rst_ev_o = fall; cap_ev_o = rise; end
      EDGE_HI_WIDTH:  begin rst_ev_o = rise; cap_ev_o = fall; end
      default:        cap_ev_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int PSEL_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [PSEL_W-1:0] presc_sel_i,
  input  logic [1:0]        edge_sel_i,
  input  logic              pin_i,
  output logic [CNT_W-1:0]  cap_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic             run_q;
  logic             tick;
  logic             cap_ev, rst_ev;
  logic             start_eff;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             wrap_q;

  assign start_eff = start_i & ~stop_i;
  // the tick coinciding with a capture/restart belongs to the next interval
  assign reload    = {{(CNT_W-1){1'b0}}, tick};

  ect_prescaler #(.PSEL_W(PSEL_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_eff),
    .en_i   (run_q),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  ect_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .mode_i   (edge_sel_i),
    .cap_ev_o (cap_ev),
    .rst_ev_o (rst_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      cap_o  <= '0;
      ovf_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (start_i) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        wrap_q <= 1'b0;
      end else if (run_q) begin
        if (cap_ev) begin
          cap_o  <= cnt_q;
          ovf_o  <= wrap_q;
          cnt_q  <= reload;
          wrap_q <= 1'b0;
          irq_o  <= 1'b1;
        end else if (rst_ev) begin
          cnt_q  <= reload;
          wrap_q <= 1'b0;
        end else if (tick) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == '1) wrap_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int CNT_W  = 16,
  parameter int PSEL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              stop_i,
  input logic [PSEL_W-1:0] presc_sel_i,
  input logic [CNT_W-1:0]  cap_o,
  input logic              ovf_o,
  input logic              irq_o,
  input logic              run_q,
  input logic              tick
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);                                          // R5
  AST_START_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> !irq_o);                           // R3
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i || !run_q) |=> !irq_o);                             // R9
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> $stable(cap_o));                                 // R4
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> $stable(ovf_o));                                 // R8
  AST_FULL_RATE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && presc_sel_i == '0) |-> tick);                     // R2
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tick);                                          // R9
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .presc_sel_i (presc_sel_i),
  .cap_o       (cap_o),
  .ovf_o       (ovf_o),
  .irq_o       (irq_o),
  .run_q       (run_q),
  .tick        (tick)
);

// File: tb/edge_capture_timer_tb.sv
module edge_capture_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXCAP     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [3:0]  presc_sel_i = 4'd0;
  logic [1:0]  edge_sel_i = 2'b01;
  logic        pin_i = 1'b0;
  logic [15:0] cap_o;
  logic        ovf_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int ncaps = 0;
  logic [15:0] caps [MAXCAP];
  logic        ovfs [MAXCAP];

  edge_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .presc_sel_i(presc_sel_i), .edge_sel_i(edge_sel_i), .pin_i(pin_i),
    .cap_o(cap_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample();
    if (irq_o && ncaps < MAXCAP) begin
      caps[ncaps] = cap_o;
      ovfs[ncaps] = ovf_o;
      ncaps++;
    end
  endtask

  // rising edges h+l clocks apart, high for h clocks
  task automatic run_wave(input int h, input int l, input int n);
    for (int p = 0; p < n; p++)
      for (int c = 0; c < h + l; c++) begin
        @(negedge clk);
        sample();
        pin_i = (c < h);
      end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      pin_i = 1'b0;
    end
  endtask

  task automatic pulse(input bit st, input bit sp);
    @(negedge clk);
    start_i = st;
    stop_i  = sp;
    @(negedge clk);
    start_i = 1'b0;
    stop_i  = 1'b0;
  endtask

  task automatic arm(input logic [1:0] mode, input logic [3:0] sel);
    pulse(1'b0, 1'b1);
    edge_sel_i  = mode;
    presc_sel_i = sel;
    pulse(1'b1, 1'b0);
    ncaps = 0;
  endtask

  task automatic t_reset();
    chk(cap_o == 16'd0, "R1 cap", cap_o, 0);
    chk(ovf_o == 1'b0, "R1 ovf", ovf_o, 0);
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    // stopped after reset: an edge gives no capture
    ncaps = 0;
    run_wave(3, 7, 2);
    drain(4);
    chk(ncaps == 0, "R1 stopped", ncaps, 0);
  endtask

  task automatic t_start_latency();
    arm(2'b01, 4'd0);
    repeat (20) @(negedge clk);
    pin_i = 1'b1;
    @(negedge clk); chk(irq_o == 1'b0, "R4 early1", irq_o, 0);
    @(negedge clk); chk(irq_o == 1'b0, "R4 early2", irq_o, 0);
    @(negedge clk); chk(irq_o == 1'b1, "R4 irq", irq_o, 1);
    chk(cap_o == 16'd22, "R3 count from start", cap_o, 22);
    chk(ovf_o == 1'b0, "R8 no wrap", ovf_o, 0);
    @(negedge clk); chk(irq_o == 1'b0, "R5 one cycle", irq_o, 0);
    pin_i = 1'b0;
    drain(3);
  endtask

  task automatic t_mode(input logic [1:0] mode, input logic [3:0] sel,
                        input int h, input int l, input int first, input int expv,
                        input string req);
    arm(mode, sel);
    run_wave(h, l, 4);
    drain(6);
    chk(ncaps == 4, req, ncaps, 4);
    for (int i = first; i < ncaps; i++)
      chk(caps[i] == 16'(expv), req, caps[i], expv);
  endtask

  task automatic t_overflow();
    arm(2'b01, 4'd0);
    run_wave(5, 65631, 1);
    ncaps = 0;
    run_wave(5, 45, 2);
    drain(4);
    chk(ncaps == 2, "R8 count", ncaps, 2);
    chk(caps[0] == 16'd100, "R8 wrapped value", caps[0], 100);
    chk(ovfs[0] == 1'b1, "R8 status set", ovfs[0], 1);
    chk(caps[1] == 16'd50, "R8 next value", caps[1], 50);
    chk(ovfs[1] == 1'b0, "R8 status clear", ovfs[1], 0);
  endtask

  task automatic t_stop();
    logic [15:0] held;
    arm(2'b01, 4'd0);
    run_wave(3, 7, 3);
    drain(4);
    held = cap_o;
    chk(held == 16'd10, "R9 before stop", held, 10);
    pulse(1'b0, 1'b1);
    ncaps = 0;
    run_wave(3, 9, 3);
    drain(4);
    chk(ncaps == 0, "R9 no irq when stopped", ncaps, 0);
    chk(cap_o == held, "R9 cap held", cap_o, held);
    pulse(1'b1, 1'b1);
    ncaps = 0;
    run_wave(3, 9, 3);
    drain(4);
    chk(ncaps == 0, "R10 stop wins", ncaps, 0);
    chk(cap_o == held, "R10 cap held", cap_o, held);
    arm(2'b01, 4'd0);
    run_wave(3, 9, 3);
    drain(4);
    chk(ncaps == 3, "R9 restart resumes", ncaps, 3);
    chk(caps[2] == 16'd12, "R9 restart value", caps[2], 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_latency();
    t_mode(2'b01, 4'd0, 5, 32, 1, 37, "R6 rising");
    t_mode(2'b00, 4'd0, 9, 20, 1, 29, "R6 falling");
    t_mode(2'b11, 4'd0, 13, 6, 0, 13, "R7 high width");
    t_mode(2'b10, 4'd0, 4, 17, 1, 17, "R7 low width");
    t_mode(2'b01, 4'd2, 4, 8, 1, 3, "R2 div4");
    t_mode(2'b01, 4'd3, 8, 24, 1, 4, "R2 div8");
    t_stop();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule